// File: doc/BRIEF.md
# Ping-Pong Record/Playback Sequencer

This block runs a store-and-replay path over two independent memory compartments. Words of 32 bits arrive on a valid/ready input stream, are written into one compartment, and are later read back and sent out on a valid/ready output stream. While one compartment is filled, the other is drained, so input and output overlap after the first half of a transfer.

A programmed transfer of N words is split into two halves of N/2 words. The first half goes into compartment 0 alone. After that, each phase writes one compartment while reading the other, and the roles swap only when both sides of the phase are complete. The whole store/read cycle runs a programmed number of times. At the end, the last half written is drained with no further writes.

Software programs a start address, a word count and a repeat count through a 16-bit register write port. It also sets a control register that holds a start bit, a read-back enable and an input-flush bit. Each compartment is modelled as a simple word-addressed port with a one-cycle read latency.

Top module: `pingpong_seq`

## Requirements
- R1: Register writes use `cmd_sel`: 0 is control, 1 and 2 are the start address low and high halves, 3 and 4 are the word count low and high halves, and 5 is the repeat count. Start address and count are each formed as {high,low}, and every register resets to 0.
- R2: Control bit 0 launches a run only when a write clears it after it was set by an earlier write. Writing it to 1 alone leaves the block idle.
- R3: A launch whose count is 0, whose count is not a multiple of 8 words, or whose repeat count is 0 leaves the block idle and sets `cfg_err`. A later valid launch clears `cfg_err`.
- R4: The first half goes only to compartment 0. In every later phase, one compartment is written while the other is read, never the same one in the same cycle, and the written compartment alternates 0,1,0,...
- R5: A phase ends only when its write half is full and its read half is fully issued. While it waits, `in_ready` is low. For repeat count R, exactly N*R input words are accepted and none is lost.
- R6: The output words equal the accepted input words, in the same order. A word held with `out_ready` low stays stable.
- R7: While control bit 1 (read-back enable) is 0, no compartment read is issued and no output word appears.
- R8: While control bit 2 (flush) is 1, `in_ready` is high and accepted words are discarded: no compartment write occurs, and those words never reach the output.
- R9: `busy` is high from the cycle after launch until the run ends. `done` is a one-cycle pulse in the first cycle `busy` is low again.
- R10: Word k of each half is written at, and read from, address start+k of its compartment.
- R11: No output word appears before N/2 words of the run have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Register write strobe |
| cmd_sel | input | 3 | Register selector |
| cmd_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Downstream accepts the output word |
| mem_wr_en | output | 2 | Write strobe per compartment |
| mem_wr_addr | output | 2x32 | Write address per compartment |
| mem_wr_data | output | 2x32 | Write data per compartment |
| mem_rd_en | output | 2 | Read strobe per compartment |
| mem_rd_addr | output | 2x32 | Read address per compartment |
| mem_rd_data | input | 2x32 | Read data per compartment, one cycle after the strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the last drain completes |
| cfg_err | output | 1 | Last launch attempt was rejected |

## Verification
The bench stalls read-back while input keeps coming. A design that swapped roles on write completion alone would accept more than two halves and overwrite unread data. The bench also flushes input in idle, where a wrong design would store or replay discarded words. It launches with malformed counts and a zero repeat, which a wrong design would run instead of rejecting. A start address near a 16-bit carry and a throttled output show whether the address halves are combined wrongly and whether data is lost or reordered under output back-pressure.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} seq_state_t;

  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_ADDR_L = 3'd1;
  localparam logic [2:0] SEL_ADDR_H = 3'd2;
  localparam logic [2:0] SEL_CNT_L  = 3'd3;
  localparam logic [2:0] SEL_CNT_H  = 3'd4;
  localparam logic [2:0] SEL_RPT    = 3'd5;

  localparam int CB_GO    = 0;
  localparam int CB_RBEN  = 1;
  localparam int CB_FLUSH = 2;
endpackage

// File: rtl/pp_cmd_regs.sv
`timescale 1ns/1ps
module pp_cmd_regs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int RPT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [2:0]        cmd_sel,
  input  logic [15:0]       cmd_wdata,
  output logic [ADDR_W-1:0] base_addr,
  output logic [CNT_W-1:0]  word_count,
  output logic [RPT_W-1:0]  repeat_cnt,
  output logic              rb_en,
  output logic              flush,
  output logic              go_pulse
);
  import pp_pkg::*;

  logic [2:0]  ctrl_q;
  logic [15:0] addr_lo, addr_hi, cnt_lo, cnt_hi, rpt_q;
  logic        unused_ctrl_bits;

  assign unused_ctrl_bits = ^cmd_wdata[15:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      addr_lo  <= '0;
      addr_hi  <= '0;
      cnt_lo   <= '0;
      cnt_hi   <= '0;
      rpt_q    <= '0;
      go_pulse <= 1'b0;
    end else begin
      go_pulse <= 1'b0;
      if (cmd_we) begin
        case (cmd_sel)
          SEL_CTRL: begin
            ctrl_q   <= cmd_wdata[2:0];
            go_pulse <= ctrl_q[CB_GO] & ~cmd_wdata[CB_GO];
          end
          SEL_ADDR_L: addr_lo <= cmd_wdata;
          SEL_ADDR_H: addr_hi <= cmd_wdata;
          SEL_CNT_L:  cnt_lo  <= cmd_wdata;
          SEL_CNT_H:  cnt_hi  <= cmd_wdata;
          SEL_RPT:    rpt_q   <= cmd_wdata;
          default: ;
        endcase
      end
    end
  end

  assign base_addr  = ADDR_W'({addr_hi, addr_lo});
  assign word_count = CNT_W'({cnt_hi, cnt_lo});
  assign repeat_cnt = RPT_W'(rpt_q);
  assign rb_en      = ctrl_q[CB_RBEN];
  assign flush      = ctrl_q[CB_FLUSH];
endmodule

// File: rtl/pp_out_fifo.sv
`timescale 1ns/1ps
module pp_out_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic                       out_valid,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] lvl;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      lvl <= lvl + LW'(push) - LW'(pop);
    end
  end

  assign out_valid = (lvl != '0);
  assign out_data  = slots[rp];
  assign level     = lvl;
endmodule

// File: rtl/pp_seq_ctrl.sv
`timescale 1ns/1ps
module pp_seq_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int RPT_W      = 16,
  parameter int GRAN_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_pulse,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic [RPT_W-1:0]  repeat_cnt,
  input  logic              wr_fire,
  input  logic              rd_fire,
  input  logic              drained,
  output logic              wr_open,
  output logic              rd_open,
  output logic              wr_bank,
  output logic [CNT_W-1:0]  wr_ofs,
  output logic [CNT_W-1:0]  rd_ofs,
  output logic [ADDR_W-1:0] base_q,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  import pp_pkg::*;

  localparam int GL   = $clog2(GRAN_WORDS);
  localparam int PH_W = RPT_W + 1;

  seq_state_t      st;
  logic [PH_W-1:0] phase, last_ph;
  logic [CNT_W-1:0] half, wcnt, rcnt;
  logic            bad_cfg, wr_act, rd_act, wr_full, rd_fin, in_run, ph_end;

  assign bad_cfg = (word_count == '0) | (word_count[GL-1:0] != '0) | (repeat_cnt == '0);
  assign in_run  = (st == S_RUN);
  assign wr_act  = (phase != last_ph);
  assign rd_act  = (phase != '0);
  assign wr_full = (wcnt == half);
  assign rd_fin  = (rcnt == half);
  assign ph_end  = in_run & (~wr_act | wr_full) & (~rd_act | rd_fin);
  assign wr_open = in_run & wr_act & ~wr_full;
  assign rd_open = in_run & rd_act & ~rd_fin;
  assign wr_bank = phase[0];
  assign wr_ofs  = wcnt;
  assign rd_ofs  = rcnt;
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      phase   <= '0;
      last_ph <= '0;
      half    <= '0;
      wcnt    <= '0;
      rcnt    <= '0;
      base_q  <= '0;
      cfg_err <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go_pulse) begin
            if (bad_cfg) begin
              cfg_err <= 1'b1;
            end else begin
              cfg_err <= 1'b0;
              st      <= S_RUN;
              phase   <= '0;
              wcnt    <= '0;
              rcnt    <= '0;
              half    <= word_count >> 1;
              last_ph <= {repeat_cnt, 1'b0};
              base_q  <= base_addr;
            end
          end
        end
        S_RUN: begin
          if (wr_fire) wcnt <= wcnt + 1'b1;
          if (rd_fire) rcnt <= rcnt + 1'b1;
          if (ph_end) begin
            if (phase == last_ph) begin
              st <= S_TAIL;
            end else begin
              phase <= phase + 1'b1;
              wcnt  <= '0;
              rcnt  <= '0;
            end
          end
        end
        S_TAIL: begin
          if (drained) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_seq.sv
`timescale 1ns/1ps
module pingpong_seq #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int RPT_W      = 16,
  parameter int GRAN_WORDS = 8,
  parameter int OBUF_DEPTH = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_we,
  input  logic [2:0]             cmd_sel,
  input  logic [15:0]            cmd_wdata,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   in_ready,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_data,
  input  logic                   out_ready,
  output logic [1:0]             mem_wr_en,
  output logic [1:0][ADDR_W-1:0] mem_wr_addr,
  output logic [1:0][DATA_W-1:0] mem_wr_data,
  output logic [1:0]             mem_rd_en,
  output logic [1:0][ADDR_W-1:0] mem_rd_addr,
  input  logic [1:0][DATA_W-1:0] mem_rd_data,
  output logic                   busy,
  output logic                   done,
  output logic                   cfg_err
);
  localparam int NBANK = 2;
  localparam int FL_W  = $clog2(OBUF_DEPTH+1);
  localparam int OCC_W = FL_W + 1;

  logic [ADDR_W-1:0] base_addr, base_q;
  logic [CNT_W-1:0]  word_count, wr_ofs, rd_ofs;
  logic [RPT_W-1:0]  repeat_cnt;
  logic              rb_en, flush, go_pulse;
  logic              wr_open, rd_open, wr_bank;
  logic              in_fire, wr_fire, rd_fire, pop, drained, room;
  logic              rd_pend, pend_bank;
  logic [FL_W-1:0]   fifo_lvl;
  logic [OCC_W-1:0]  occ;

  pp_cmd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RPT_W(RPT_W)) u_regs (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
    .base_addr(base_addr), .word_count(word_count), .repeat_cnt(repeat_cnt),
    .rb_en(rb_en), .flush(flush), .go_pulse(go_pulse)
  );

  pp_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RPT_W(RPT_W), .GRAN_WORDS(GRAN_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .go_pulse(go_pulse), .base_addr(base_addr),
    .word_count(word_count), .repeat_cnt(repeat_cnt),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .drained(drained),
    .wr_open(wr_open), .rd_open(rd_open), .wr_bank(wr_bank),
    .wr_ofs(wr_ofs), .rd_ofs(rd_ofs), .base_q(base_q),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  assign in_ready = flush | wr_open;
  assign in_fire  = in_valid & in_ready;
  assign wr_fire  = in_fire & ~flush;
  assign pop      = out_valid & out_ready;
  assign occ      = OCC_W'(fifo_lvl) + OCC_W'(rd_pend);
  assign room     = (occ - OCC_W'(pop)) < OCC_W'(OBUF_DEPTH);
  assign rd_fire  = rd_open & rb_en & room;
  assign drained  = ~rd_pend & (fifo_lvl == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      pend_bank <= 1'b0;
    end else begin
      rd_pend   <= rd_fire;
      pend_bank <= ~wr_bank;
    end
  end

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign mem_wr_en[b]   = wr_fire & (wr_bank == 1'(b));
      assign mem_wr_addr[b] = base_q + ADDR_W'(wr_ofs);
      assign mem_wr_data[b] = in_data;
      assign mem_rd_en[b]   = rd_fire & (wr_bank != 1'(b));
      assign mem_rd_addr[b] = base_q + ADDR_W'(rd_ofs);
    end
  endgenerate

  pp_out_fifo #(.W(DATA_W), .DEPTH(OBUF_DEPTH)) u_obuf (
    .clk(clk), .rst(rst), .push(rd_pend), .push_data(mem_rd_data[pend_bank]),
    .pop(pop), .out_valid(out_valid), .out_data(out_data), .level(fifo_lvl)
  );
endmodule

// File: rtl/pp_checker.sv
`timescale 1ns/1ps
module pp_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              cfg_err,
  input logic              go_pulse,
  input logic              rb_en,
  input logic              flush,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        mem_wr_en,
  input logic [1:0]        mem_rd_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R2
  launch_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go_pulse));

  // R7
  readback_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en != 2'b00) |-> rb_en);

  // R8
  flush_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (mem_wr_en == 2'b00));

  // R4
  bank_roles_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_wr_en) && $onehot0(mem_rd_en) && ((mem_wr_en & mem_rd_en) == 2'b00));

  // R5
  write_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en != 2'b00) |-> (in_valid && in_ready));

  // R3
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind pingpong_seq pp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .cfg_err(cfg_err),
  .go_pulse(go_pulse), .rb_en(rb_en), .flush(flush),
  .in_valid(in_valid), .in_ready(in_ready),
  .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_pingpong_seq.sv
`timescale 1ns/1ps
module sim_pingpong_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_sel = '0;
  logic [15:0] cmd_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'h1000_0000;
  logic        in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] out_data;
  logic [1:0]  mem_wr_en, mem_rd_en;
  logic [1:0][31:0] mem_wr_addr, mem_wr_data, mem_rd_addr;
  logic [1:0][31:0] mem_rd_data = '0;
  logic        busy, done, cfg_err;

  pingpong_seq u0 (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  // compartment models, one-cycle read latency
  logic [31:0] mem0 [logic [31:0]];
  logic [31:0] mem1 [logic [31:0]];
  always @(posedge clk) begin
    if (mem_wr_en[0]) mem0[mem_wr_addr[0]] = mem_wr_data[0];
    if (mem_wr_en[1]) mem1[mem_wr_addr[1]] = mem_wr_data[1];
    if (mem_rd_en[0]) mem_rd_data[0] <= mem0.exists(mem_rd_addr[0]) ? mem0[mem_rd_addr[0]] : 32'hDEAD_0000;
    if (mem_rd_en[1]) mem_rd_data[1] <= mem1.exists(mem_rd_addr[1]) ? mem1[mem_rd_addr[1]] : 32'hDEAD_0001;
  end

  int checks = 0, failures = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] exp_q[$];
  logic [31:0] base_m = '0;
  int          half_m = 0;
  bit          rb_m = 0, flush_m = 0, acc_flag = 0, overlap = 0, first_out = 1;
  bit          ready_mode = 0;
  int          wr_n = 0, out_n = 0, acc_run = 0, flushed_n = 0, done_seen = 0;
  logic [31:0] first_wr_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (in_valid && in_ready) begin
        acc_flag = 1;
        if (flush_m) flushed_n++;
        else begin
          exp_q.push_back(in_data);
          acc_run++;
        end
      end
      if (mem_wr_en != 2'b00) begin
        if (flush_m) chk(0, "R8", "write during flush", mem_wr_en, 0);
        if (half_m != 0) begin
          int eb, ea;
          eb = (wr_n / half_m) % 2;
          ea = base_m + (wr_n % half_m);
          if (wr_n == 0) first_wr_addr = mem_wr_addr[eb];
          chk(mem_wr_en == 2'(1 << eb), "R4", "write compartment", mem_wr_en, 2'(1 << eb));
          chk(mem_wr_addr[eb] == 32'(ea), "R10", "write address", mem_wr_addr[eb], 32'(ea));
        end
        wr_n++;
      end
      if ((mem_rd_en != 2'b00) && (mem_wr_en != 2'b00)) overlap = 1;
      if ((mem_rd_en != 2'b00) && !rb_m) chk(0, "R7", "read while disabled", mem_rd_en, 0);
      if (out_valid && !rb_m) chk(0, "R7", "output while disabled", 1, 0);
      if (out_valid && out_ready) begin
        if (first_out) begin
          chk(acc_run >= half_m, "R11", "words accepted before first output", acc_run, half_m);
          first_out = 0;
        end
        if (exp_q.size() == 0) chk(0, "R6", "unexpected output", out_data, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R6", "output word", out_data, e);
        end
        out_n++;
      end
      if (done) begin
        done_seen++;
        chk(!busy, "R9", "busy low with done", busy, 0);
      end
    end
  end

  // input data advance and output throttle
  always @(posedge clk) begin
    cyc++;
    #1;
    if (acc_flag) begin
      in_data = in_data + 32'h9E37_79B9;
      acc_flag = 0;
    end
    out_ready = ready_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wcmd(input logic [2:0] sel, input logic [15:0] d);
    cmd_we = 1'b1; cmd_sel = sel; cmd_wdata = d;
    step(1);
    cmd_we = 1'b0;
  endtask

  task automatic start_run(input logic [15:0] alo, ahi, clo, chi, rpt, input bit rb);
    wcmd(3'd1, alo); wcmd(3'd2, ahi); wcmd(3'd3, clo); wcmd(3'd4, chi); wcmd(3'd5, rpt);
    base_m = {ahi, alo};
    half_m = int'({chi, clo} >> 1);
    wr_n = 0; out_n = 0; acc_run = 0; overlap = 0; first_out = 1;
    wcmd(3'd0, {13'd0, 1'b0, rb, 1'b1});
    rb_m = rb;
    step(3);
    chk(busy == 1'b0, "R2", "busy after set only", busy, 0);
    wcmd(3'd0, {13'd0, 1'b0, rb, 1'b0});
  endtask

  task automatic wait_done(input string req);
    int start_seen, n;
    start_seen = done_seen;
    n = 0;
    while (done_seen == start_seen && n < 4000) begin
      step(1);
      n++;
    end
    chk(done_seen == start_seen + 1, req, "done reached", done_seen - start_seen, 1);
    step(3);
    chk(done_seen == start_seen + 1, "R9", "single done pulse", done_seen - start_seen, 1);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    chk(busy == 0 && done == 0 && cfg_err == 0, "R9", "reset status", {busy, done, cfg_err}, 0);
    chk(out_valid == 0 && in_ready == 0, "R1", "reset stream state", {out_valid, in_ready}, 0);

    // R1: count resets to 0, so a bare launch is rejected
    wcmd(3'd0, 16'h0001);
    wcmd(3'd0, 16'h0000);
    step(2);
    chk(cfg_err == 1 && busy == 0, "R1", "launch with reset count", {cfg_err, busy}, 2);

    // main run: 16 words, 2 repeats
    in_valid = 1'b1;
    start_run(16'h0010, 16'h0001, 16'd16, 16'd0, 16'd2, 1'b1);
    step(1);
    chk(busy == 1, "R2", "busy after clear", busy, 1);
    chk(cfg_err == 0, "R3", "error cleared by valid launch", cfg_err, 0);
    wait_done("R9");
    chk(first_wr_addr == 32'h0001_0010, "R1", "combined start address", first_wr_addr, 32'h0001_0010);
    chk(out_n == 32, "R6", "outputs for two repeats", out_n, 32);
    chk(acc_run == 32, "R5", "inputs accepted", acc_run, 32);
    chk(overlap == 1, "R4", "concurrent write and read", overlap, 1);
    chk(exp_q.size() == 0, "R6", "nothing left pending", exp_q.size(), 0);

    // back-pressure with read-back disabled
    start_run(16'h0000, 16'h0000, 16'd8, 16'd0, 16'd3, 1'b0);
    step(60);
    chk(acc_run == 8, "R5", "accepted while stalled", acc_run, 8);
    chk(out_n == 0, "R7", "no output while disabled", out_n, 0);
    chk(in_ready == 0, "R5", "input held off", in_ready, 0);
    chk(busy == 1, "R9", "busy while stalled", busy, 1);
    wcmd(3'd0, 16'h0002);
    rb_m = 1;
    wait_done("R5");
    chk(out_n == 24, "R6", "outputs after release", out_n, 24);
    chk(acc_run == 24, "R5", "total accepted", acc_run, 24);

    // flush in idle
    wcmd(3'd0, 16'h0004);
    flush_m = 1;
    step(10);
    chk(in_ready == 1, "R8", "ready while flushing", in_ready, 1);
    chk(flushed_n > 0, "R8", "words discarded", flushed_n, 1);
    wcmd(3'd0, 16'h0000);
    flush_m = 0;
    step(1);
    chk(in_ready == 0, "R8", "idle ready after flush", in_ready, 0);
    start_run(16'h0100, 16'h0000, 16'd8, 16'd0, 16'd1, 1'b1);
    wait_done("R8");
    chk(out_n == 8 && exp_q.size() == 0, "R8", "only kept words replayed", out_n, 8);

    // rejected launches
    start_run(16'h0000, 16'h0000, 16'd12, 16'd0, 16'd1, 1'b1);
    step(2);
    chk(cfg_err == 1 && busy == 0, "R3", "count not multiple of 8", {cfg_err, busy}, 2);
    start_run(16'h0000, 16'h0000, 16'd0, 16'd0, 16'd1, 1'b1);
    step(2);
    chk(cfg_err == 1 && busy == 0, "R3", "zero count", {cfg_err, busy}, 2);
    start_run(16'h0000, 16'h0000, 16'd16, 16'd0, 16'd0, 1'b1);
    step(2);
    chk(cfg_err == 1 && busy == 0, "R3", "zero repeat", {cfg_err, busy}, 2);
    chk(acc_run == 0, "R3", "no input taken when rejected", acc_run, 0);
    start_run(16'h0000, 16'h0000, 16'd8, 16'd0, 16'd1, 1'b1);
    step(2);
    chk(cfg_err == 0 && busy == 1, "R3", "valid launch after errors", {cfg_err, busy}, 1);
    wait_done("R3");

    // address carry across halves, throttled output
    ready_mode = 1;
    start_run(16'hFFF8, 16'h0002, 16'd32, 16'd0, 16'd2, 1'b1);
    wait_done("R10");
    chk(out_n == 64, "R6", "outputs under throttle", out_n, 64);
    chk(acc_run == 64, "R5", "accepted under throttle", acc_run, 64);
    ready_mode = 0;
    in_valid = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule